// File: doc/BRIEF.md
# Write-Permission Status Register

This block keeps the protection state for a small serial byte memory and rules on every write the serial front end wants to make. It holds a write-enable latch and a two-bit block-protect field. It also samples the active-low hardware write-protect pin. The serial front end sends it single-cycle pulses for these events: latch set, latch clear, start of a data byte, a status write with its data byte, a memory byte write with its address, and the end of a write command. For each write request the block returns a registered grant or deny. It also presents an 8-bit status value for reads.

A write is granted only when three conditions all hold: the latch is set, the pin was high when the current byte began, and, for a memory byte, the address lies outside the range that the block-protect field selects. The latch stays set through a multi-byte burst, so each byte of a burst is judged on its own address. The latch clears when the write command ends. The block-protect field survives latch changes and command ends, and only the reset input clears it.

Top module: `wrprot_status`

## Requirements
- R1: After reset, `status_o` reads 00h, the latch is clear, the protect field is 00, and no grant or deny pulses.
- R2: A `wel_set_i` pulse sets the latch, which reads as status bit 1. A `wel_clr_i` pulse clears it. When both pulse in the same cycle, the latch ends up clear.
- R3: A granted status write loads status bits 3:2 from data bits 3:2. Status bits 7:4 and bit 0 always read 0, and data bit 1 does not change the latch.
- R4: A `wr_op_done_i` pulse clears the latch. It does not change the protect field.
- R5: While the latch is clear, every memory byte write is denied and every status write is refused, leaving the status unchanged.
- R6: While the latch is set but the captured pin level is low, every memory byte write is denied and every status write is refused.
- R7: Protect field decoding: 00 protects nothing, 01 protects 180h–1FFh, 10 protects 100h–1FFh, and 11 protects 000h–1FFh. A write to a protected address is denied even when the latch is set and the pin is high.
- R8: The pin level is captured on `byte_start_i`. A pin change after that capture does not affect the byte in flight, but it does apply from the next captured byte.
- R9: Each byte of a burst is checked against its own address. A denied byte leaves the latch set, so later bytes at unprotected addresses are still granted.
- R10: One cycle after each memory write request, exactly one of `mem_wr_ok_o` and `mem_wr_deny_o` pulses. Neither pulses in any other cycle.
- R11: The reset input clears a protect field that was set earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also clears protect field |
| wel_set_i | input | 1 | Pulse: set write-enable latch |
| wel_clr_i | input | 1 | Pulse: clear write-enable latch |
| wr_op_done_i | input | 1 | Pulse: a write command has ended |
| byte_start_i | input | 1 | Pulse: a data byte begins; pin level is captured |
| wp_n_i | input | 1 | Hardware write-protect pin, low protects |
| sr_wr_req_i | input | 1 | Pulse: status write request |
| sr_wr_data_i | input | 8 | Status write data byte |
| mem_wr_req_i | input | 1 | Pulse: memory byte write request |
| mem_wr_addr_i | input | 9 | Byte address of the memory write |
| mem_wr_ok_o | output | 1 | Memory write granted (registered pulse) |
| mem_wr_deny_o | output | 1 | Memory write denied (registered pulse) |
| sr_wr_ok_o | output | 1 | Status write accepted (registered pulse) |
| status_o | output | 8 | Status value: bits 3:2 protect field, bit 1 latch |

## Verification
Memory writes are tried under four gating patterns: latch clear, latch set with the pin low, latch set with the pin high, and the pin dropping in the middle of a byte. This shows which of the three tiers caused each denial. Every protect setting is then tested with addresses on both sides of each range edge (0FFh/100h, 17Fh/180h, 000h/1FFh), which catches a wrong decode bit. A burst that crosses 180h under quarter protection separates checking each byte from ending the burst on the first denied byte. Status writes with all-ones data show that fixed bits and the latch cannot be written.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
  localparam int STAT_W  = 8;
  localparam int WEL_POS = 1;
  localparam int BP_POS  = 2;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_t;
endpackage

// File: rtl/wrprot_wel.sv
module wrprot_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  // clear has priority over set
  always_ff @(posedge clk) begin
    if (rst)        wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/wrprot_pincap.sv
module wrprot_pincap (
  input  logic clk,
  input  logic rst,
  input  logic capture_i,
  input  logic pin_n_i,
  output logic allow_o
);
  // level held for the whole byte; reset value is the protective one
  always_ff @(posedge clk) begin
    if (rst)            allow_o <= 1'b0;
    else if (capture_i) allow_o <= pin_n_i;
  end
endmodule

// File: rtl/wrprot_range.sv
module wrprot_range
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  bp_t               bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (bp_i)
      BP_NONE:    locked_o = 1'b0;
      BP_QUARTER: locked_o = (addr_i[TOP -: 2] == 2'b11);
      BP_HALF:    locked_o = addr_i[TOP];
      default:    locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrprot_status.sv
module wrprot_status
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              wr_op_done_i,
  input  logic              byte_start_i,
  input  logic              wp_n_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              mem_wr_req_i,
  input  logic [ADDR_W-1:0] mem_wr_addr_i,
  output logic              mem_wr_ok_o,
  output logic              mem_wr_deny_o,
  output logic              sr_wr_ok_o,
  output logic [7:0]        status_o
);
  logic wel_q;
  logic pin_ok_q;
  bp_t  bp_q;
  logic locked;
  logic gate_open;
  logic mem_grant;
  logic sr_grant;
  logic unused_sr_bits;

  assign unused_sr_bits = ^{sr_wr_data_i[7:4], sr_wr_data_i[1:0]};

  wrprot_wel u_wel (
    .clk   (clk),
    .rst   (rst),
    .set_i (wel_set_i),
    .clr_i (wel_clr_i | wr_op_done_i),
    .wel_o (wel_q)
  );

  wrprot_pincap u_pin (
    .clk       (clk),
    .rst       (rst),
    .capture_i (byte_start_i),
    .pin_n_i   (wp_n_i),
    .allow_o   (pin_ok_q)
  );

  wrprot_range #(.ADDR_W(ADDR_W)) u_rng (
    .bp_i     (bp_q),
    .addr_i   (mem_wr_addr_i),
    .locked_o (locked)
  );

  assign gate_open = wel_q & pin_ok_q;
  assign mem_grant = mem_wr_req_i & gate_open & ~locked;
  assign sr_grant  = sr_wr_req_i & gate_open;

  // protect field: cleared only by reset
  always_ff @(posedge clk) begin
    if (rst)           bp_q <= BP_NONE;
    else if (sr_grant) bp_q <= bp_t'(sr_wr_data_i[BP_POS +: 2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_ok_o   <= 1'b0;
      mem_wr_deny_o <= 1'b0;
      sr_wr_ok_o    <= 1'b0;
      status_o      <= '0;
    end else begin
      mem_wr_ok_o   <= mem_grant;
      mem_wr_deny_o <= mem_wr_req_i & ~mem_grant;
      sr_wr_ok_o    <= sr_grant;
      status_o                 <= '0;
      status_o[BP_POS +: 2]    <= bp_q;
      status_o[WEL_POS]        <= wel_q;
    end
  end
endmodule

// File: rtl/wrprot_chk.sv
module wrprot_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_op_done_i,
  input logic              sr_wr_req_i,
  input logic [7:0]        sr_wr_data_i,
  input logic              mem_wr_req_i,
  input logic [ADDR_W-1:0] mem_wr_addr_i,
  input logic              mem_wr_ok_o,
  input logic              mem_wr_deny_o,
  input logic              sr_wr_ok_o,
  input logic [7:0]        status_o,
  input logic              wel_q,
  input logic              pin_ok_q,
  input logic [1:0]        bp_q
);
  a_r10_one_answer: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req_i |=> ($countones({mem_wr_ok_o, mem_wr_deny_o}) == 1));

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_req_i |=> (!mem_wr_ok_o && !mem_wr_deny_o));

  a_r3_fixed_zero: assert property (@(posedge clk) disable iff (rst)
    (status_o[7:4] == 4'h0) && !status_o[0]);

  a_r5_grant_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_ok_o || sr_wr_ok_o) |-> $past(wel_q));

  a_r6_grant_needs_pin: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_ok_o || sr_wr_ok_o) |-> $past(pin_ok_q));

  a_r7_all_locked: assert property (@(posedge clk) disable iff (rst)
    mem_wr_ok_o |-> ($past(bp_q) != 2'b11));

  a_r3_bp_loaded: assert property (@(posedge clk) disable iff (rst)
    sr_wr_ok_o |-> (bp_q == $past(sr_wr_data_i[3:2])));

  a_r4_done_clears: assert property (@(posedge clk) disable iff (rst)
    wr_op_done_i |=> !wel_q);

  a_r4_bp_kept: assert property (@(posedge clk) disable iff (rst)
    !sr_wr_req_i |=> $stable(bp_q));

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (bp_q == 2'b00 && !wel_q));

  logic unused_addr;
  assign unused_addr = ^mem_wr_addr_i;
endmodule

bind wrprot_status wrprot_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_op_done_i  (wr_op_done_i),
  .sr_wr_req_i   (sr_wr_req_i),
  .sr_wr_data_i  (sr_wr_data_i),
  .mem_wr_req_i  (mem_wr_req_i),
  .mem_wr_addr_i (mem_wr_addr_i),
  .mem_wr_ok_o   (mem_wr_ok_o),
  .mem_wr_deny_o (mem_wr_deny_o),
  .sr_wr_ok_o    (sr_wr_ok_o),
  .status_o      (status_o),
  .wel_q         (wel_q),
  .pin_ok_q      (pin_ok_q),
  .bp_q          (bp_q)
);

// File: tb/sim_wrprot_status.sv
`timescale 1ns/1ps
module sim_wrprot_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wel_set = 0, wel_clr = 0, op_done = 0, bstart = 0, wp_n = 1;
  logic       sr_req = 0;
  logic [7:0] sr_data = 0;
  logic       mem_req = 0;
  logic [8:0] mem_addr = 0;
  logic       mem_ok, mem_deny, sr_ok;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;
  bit m_wel = 0;
  bit m_pin = 0;
  logic [1:0] m_bp = 2'b00;

  always #4 clk = ~clk;

  wrprot_status u0 (
    .clk(clk), .rst(rst), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .wr_op_done_i(op_done), .byte_start_i(bstart), .wp_n_i(wp_n),
    .sr_wr_req_i(sr_req), .sr_wr_data_i(sr_data), .mem_wr_req_i(mem_req),
    .mem_wr_addr_i(mem_addr), .mem_wr_ok_o(mem_ok), .mem_wr_deny_o(mem_deny),
    .sr_wr_ok_o(sr_ok), .status_o(status)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit locked(input logic [1:0] bp, input logic [8:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a >= 9'h180;
      2'b10: return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    m_wel = 0; m_pin = 0; m_bp = 2'b00;
  endtask

  task automatic pulse_set(); @(negedge clk); wel_set = 1; @(negedge clk); wel_set = 0; m_wel = 1; endtask
  task automatic pulse_clr(); @(negedge clk); wel_clr = 1; @(negedge clk); wel_clr = 0; m_wel = 0; endtask
  task automatic pulse_done(); @(negedge clk); op_done = 1; @(negedge clk); op_done = 0; m_wel = 0; endtask

  task automatic byte_go(input logic pin);
    @(negedge clk); wp_n = pin; bstart = 1;
    @(negedge clk); bstart = 0; m_pin = pin;
  endtask

  task automatic status_is(input string req);
    @(negedge clk); @(negedge clk);
    check(req, {1'b0, status}, {1'b0, 4'h0, m_bp, m_wel, 1'b0});
  endtask

  task automatic mem_wr(input string req, input logic [8:0] a);
    bit exp_ok;
    exp_ok = m_wel && m_pin && !locked(m_bp, a);
    @(negedge clk); mem_req = 1; mem_addr = a;
    @(negedge clk);
    check(req, {7'b0, mem_ok, mem_deny}, {7'b0, exp_ok, !exp_ok});
    mem_req = 0;
    @(negedge clk);
    check("R10 idle", {7'b0, mem_ok, mem_deny}, 9'h0);
  endtask

  task automatic sr_wr(input string req, input logic [7:0] d);
    bit exp_ok;
    exp_ok = m_wel && m_pin;
    @(negedge clk); sr_req = 1; sr_data = d;
    @(negedge clk);
    check(req, {8'b0, sr_ok}, {8'b0, exp_ok});
    sr_req = 0;
    if (exp_ok) m_bp = d[3:2];
  endtask

  task automatic set_bp(input logic [1:0] bp);
    pulse_set(); byte_go(1'b1); sr_wr("R3 setup", {4'h0, bp, 2'b00}); pulse_done();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 status", {1'b0, status}, 9'h0);
    check("R1 pulses", {6'b0, mem_ok, mem_deny, sr_ok}, 9'h0);
  endtask

  task automatic t_latch();
    pulse_set();  status_is("R2 set");
    pulse_clr();  status_is("R2 clear");
    @(negedge clk); wel_set = 1; wel_clr = 1;
    @(negedge clk); wel_set = 0; wel_clr = 0; m_wel = 0;
    status_is("R2 both");
  endtask

  task automatic t_no_wel();
    byte_go(1'b1);
    mem_wr("R5 mem", 9'h000);
    sr_wr("R5 sr", 8'h0C);
    status_is("R5 status");
  endtask

  task automatic t_sr_write();
    pulse_set(); byte_go(1'b1);
    sr_wr("R3 accept", 8'hFD);      // bit1 clear in data, latch must stay
    status_is("R3 fields");
    pulse_done(); status_is("R4 done");
    sr_wr("R3 second", 8'hF0);
    pulse_clr(); pulse_set(); byte_go(1'b1);
    sr_wr("R3 zero", 8'hF3);
    status_is("R3 masked");
    pulse_done();
  endtask

  task automatic t_pin_low();
    pulse_set(); byte_go(1'b0);
    mem_wr("R6 mem", 9'h010);
    sr_wr("R6 sr", 8'h08);
    status_is("R6 status");
    pulse_done();
  endtask

  task automatic t_ranges();
    logic [8:0] probes [6] = '{9'h000, 9'h0FF, 9'h100, 9'h17F, 9'h180, 9'h1FF};
    for (int b = 0; b < 4; b++) begin
      set_bp(b[1:0]);
      pulse_set();
      for (int i = 0; i < 6; i++) begin
        byte_go(1'b1);
        mem_wr("R7 range", probes[i]);
      end
      pulse_done();
    end
  endtask

  task automatic t_pin_midbyte();
    set_bp(2'b00);
    pulse_set(); byte_go(1'b1);
    @(negedge clk); wp_n = 0;          // drop after capture
    mem_wr("R8 in flight", 9'h020);
    byte_go(1'b0);
    mem_wr("R8 next byte", 9'h021);
    pulse_done();
  endtask

  task automatic t_burst();
    set_bp(2'b01);
    pulse_set();
    for (int i = 0; i < 4; i++) begin
      byte_go(1'b1);
      mem_wr("R9 burst", 9'h17E + 9'(i));
    end
    status_is("R9 latch kept");
    byte_go(1'b1); mem_wr("R9 after deny", 9'h000);
    pulse_done();
  endtask

  task automatic t_reset_bp();
    set_bp(2'b11);
    status_is("R11 before");
    do_reset();
    status_is("R11 cleared");
  endtask

  bit done = 0;
  initial begin
    do_reset();
    t_reset();
    t_latch();
    t_no_wel();
    t_sr_write();
    t_pin_low();
    t_ranges();
    t_pin_midbyte();
    t_burst();
    t_reset_bp();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule